// File: doc/BRIEF.md
# Rate-Paced Video Output Stage

This block turns bursty active-pixel writes into an unbroken output pixel stream that is timed only by the system clock. Incoming pixels enter an elastic FIFO together with a tag that marks the first pixel of each line. A pacing stage then drains the FIFO. In full-rate mode it drains one pixel on every system clock. In half-rate mode it drains one pixel on every other clock, which gives a pixel enable with a 50% duty cycle. No second pixel clock is used.

A line begins only when the FIFO holds enough data to finish it without a gap. That means either a programmable number of words is stored, or the whole line is stored, shown by the start tag of the following line being present. Once a line has begun, the stage emits pixels at the paced rate until the next line's start tag reaches the FIFO head. The stage then stops and waits to be primed again. If the FIFO runs dry in the middle of a line, a sticky underrun flag is raised and the last pixel is repeated. A full flag holds the writer back. DEPTH must be a power of two.

Top module: `vid_pace_out`

## Requirements
- R1: After reset, `pix_en`, `pix_data`, `underrun` and `wr_full` are all 0.
- R2: In full-rate mode (`half_rate`=0), a started line asserts `pix_en` on consecutive cycles and presents the pixels in the order they were written.
- R3: In half-rate mode (`half_rate`=1), `pix_en` alternates high and low within a line, so consecutive pixels are exactly two cycles apart.
- R4: The first pixel of a line is asserted on the very first cycle the line is active, so the half-rate phase is the same at every line start.
- R5: With the FIFO holding N words, a line starts only when N ≥ `prime_level` and N > 0. A `prime_level` above DEPTH never starts a line by count.
- R6: The first `pix_en` of a line appears two clock edges after the edge that accepted the write meeting the start condition.
- R7: A line also starts below `prime_level` once two start-tagged words are stored (the head line plus the next line's start).
- R8: While a line is running, reaching a start-tagged word at the FIFO head (other than the line's own first pixel) ends the line. `pix_en` then stays 0 until the start condition holds again. The tagged word is kept as the first pixel of the next line.
- R9: If the FIFO is empty on a pixel slot during a line, `pix_en` is still asserted, `pix_data` repeats the last pixel, and `underrun` becomes 1 and stays 1 until reset.
- R10: `wr_full` is 1 exactly when DEPTH words are stored. A write while `wr_full` is 1 is discarded.
- R11: `pix_data` changes only on cycles where `pix_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one pixel |
| wr_data | input | DW | Pixel value written |
| wr_sol | input | 1 | Marks the written pixel as the first of a line |
| wr_full | output | 1 | FIFO holds DEPTH words; writes are dropped |
| half_rate | input | 1 | 0: one pixel per clock; 1: one pixel per two clocks |
| prime_level | input | AW+1 | Word count that allows a line to start |
| pix_en | output | 1 | Output pixel valid |
| pix_data | output | DW | Output pixel value |
| underrun | output | 1 | Sticky: FIFO was empty during a line |

## Verification
The FIFO count updates on the edge that accepts a write. The line-active state follows one edge later, and the first `pix_en` one edge after that. The bench therefore writes on a falling edge and expects output exactly two falling edges after the accepting rising edge. Every sample is taken on a falling edge, so registered outputs are read half a cycle after they change. A monitor stamps each asserted pixel with the rising-edge count. Pixel spacing of one or two cycles and the line start time are then checked as differences of those stamps against values computed from the write schedule. The underrun, line-end and full cases are checked on the exact falling edge where the counted pipeline says they must appear.

// File: rtl/vid_pace_out.sv
`timescale 1ns/1ps
module vid_pace_out #(
  parameter int DW    = 24,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         wr_sol,
  output logic                         wr_full,
  input  logic                         half_rate,
  input  logic [$clog2(DEPTH):0]       prime_level,
  output logic                         pix_en,
  output logic [DW-1:0]                pix_data,
  output logic                         underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count, sol_cnt;
  logic          active, ph, started;

  wire [DW:0] head     = mem[rp];
  wire        head_sol = head[DW];
  wire        nonempty = (count != '0);

  assign wr_full = (count == CW'(DEPTH));

  wire push     = wr_en && !wr_full;
  wire slot     = active && (!half_rate || !ph);
  wire line_end = slot && started && nonempty && head_sol;
  wire pop      = slot && nonempty && !line_end;
  wire start_ok = !active && nonempty &&
                  ((count >= prime_level) || (sol_cnt >= CW'(2)));

  always_ff @(posedge clk)
    if (push) mem[wp] <= {wr_sol, wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      sol_cnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      count   <= count + CW'(push) - CW'(pop);
      sol_cnt <= sol_cnt + CW'(push && wr_sol) - CW'(pop && head_sol);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      ph       <= 1'b0;
      started  <= 1'b0;
      pix_en   <= 1'b0;
      pix_data <= '0;
      underrun <= 1'b0;
    end else if (!active) begin
      pix_en <= 1'b0;
      if (start_ok) begin
        active  <= 1'b1;
        ph      <= 1'b0;
        started <= 1'b0;
      end
    end else begin
      ph <= ~ph;
      if (!slot) begin
        pix_en <= 1'b0;
      end else if (line_end) begin
        active <= 1'b0;
        pix_en <= 1'b0;
      end else if (pop) begin
        pix_en   <= 1'b1;
        pix_data <= head[DW-1:0];
        started  <= 1'b1;
      end else begin
        pix_en   <= 1'b1;
        underrun <= 1'b1;
      end
    end
  end

  // R10: stored words never exceed the depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)) else $error("fifo count beyond depth");

  // R10: full stays set while nothing is drained
  p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full && !pop) |=> wr_full) else $error("full dropped without a read");

  // R3: half-rate enable never high on two adjacent cycles
  p_half_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && half_rate && $stable(half_rate)) |=> !pix_en)
    else $error("half-rate enable high twice in a row");

  // R9: underrun flag is sticky
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun) else $error("underrun cleared");

  // R11: data holds when no pixel is emitted
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |-> $stable(pix_data)) else $error("pix_data moved without pix_en");

  // R5: nothing is emitted on the cycle after an idle cycle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pix_en) else $error("pixel emitted while idle");
endmodule

// File: tb/vid_pace_out_bench.sv
`timescale 1ns/1ps
module vid_pace_out_bench;
  localparam int DW = 24;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_sol = 1'b0;
  logic wr_full;
  logic half_rate = 1'b0;
  logic [CW-1:0] prime_level = '0;
  logic pix_en;
  logic [DW-1:0] pix_data;
  logic underrun;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;

  logic [DW-1:0] out_d[$];
  int            out_c[$];
  logic [DW-1:0] exp_d[$];
  bit            exp_first[$];

  vid_pace_out #(.DW(DW), .DEPTH(DEPTH)) u_vid_pace_out (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_sol(wr_sol), .wr_full(wr_full), .half_rate(half_rate),
    .prime_level(prime_level), .pix_en(pix_en), .pix_data(pix_data),
    .underrun(underrun));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && pix_en) begin
      out_d.push_back(pix_data);
      out_c.push_back(cyc);
    end

  function automatic int exp_gap(input bit half);
    return half ? 2 : 1;
  endfunction

  function automatic logic [DW-1:0] rnd_pix();
    return DW'($urandom);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_sol = 1'b0;
    repeat (3) @(negedge clk);
    out_d.delete();
    out_c.delete();
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [DW-1:0] d, input bit s);
    while (wr_full) @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    wr_sol = s;
    @(negedge clk);
    wr_en = 1'b0;
    wr_sol = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] w[8];
    logic [DW-1:0] s1, s2;
    int e4;
    void'($urandom(32'd2024));

    // Scenario A: priming, full rate, underrun, line end, start by tags
    @(negedge clk);
    do_reset();
    half_rate = 1'b0;
    prime_level = CW'(8);
    @(negedge clk);
    check("R1 pix_en", int'(pix_en), 0);
    check("R1 pix_data", int'(pix_data), 0);
    check("R1 underrun", int'(underrun), 0);
    check("R1 wr_full", int'(wr_full), 0);
    for (int i = 0; i < 8; i++) begin
      w[i] = rnd_pix();
      wr(w[i], i == 0);
      check("R5 idle below prime", int'(pix_en), 0);
      if (i == 6)
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          check("R5 idle waiting", int'(pix_en), 0);
        end
    end
    @(negedge clk);
    check("R6 not yet", int'(pix_en), 0);
    @(negedge clk);
    check("R6 first pixel en", int'(pix_en), 1);
    check("R6 first pixel data", int'(pix_data), int'(w[0]));
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      check("R2 contiguous en", int'(pix_en), 1);
      check("R2 order", int'(pix_data), int'(w[i]));
      check("R9 no early underrun", int'(underrun), 0);
    end
    @(negedge clk);
    check("R9 en kept", int'(pix_en), 1);
    check("R9 flag", int'(underrun), 1);
    check("R9 repeat", int'(pix_data), int'(w[7]));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 repeat hold en", int'(pix_en), 1);
      check("R9 repeat hold data", int'(pix_data), int'(w[7]));
    end
    s1 = rnd_pix();
    wr(s1, 1'b1);
    @(negedge clk);
    check("R8 line stops", int'(pix_en), 0);
    check("R9 sticky", int'(underrun), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 stays idle", int'(pix_en), 0);
    end
    s2 = rnd_pix();
    wr(s2, 1'b1);
    check("R7 not yet", int'(pix_en), 0);
    @(negedge clk);
    check("R7 not yet", int'(pix_en), 0);
    @(negedge clk);
    check("R7 tag start en", int'(pix_en), 1);
    check("R7 tag start data", int'(pix_data), int'(s1));
    @(negedge clk);
    check("R8 next tag ends line", int'(pix_en), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 waits", int'(pix_en), 0);
      check("R11 data held", int'(pix_data), int'(s1));
    end

    // Scenario B: half rate, phase at line start
    do_reset();
    half_rate = 1'b1;
    prime_level = CW'(4);
    e4 = 0;
    for (int i = 0; i < 6; i++) begin
      w[i] = rnd_pix();
      wr(w[i], i == 0);
      if (i == 3) e4 = cyc;
    end
    wr(rnd_pix(), 1'b1);
    repeat (20) @(negedge clk);
    check("R3 pixel count", out_d.size(), 6);
    if (out_d.size() == 6) begin
      check("R4 first slot", out_c[0], e4 + 2);
      for (int i = 0; i < 6; i++) begin
        check("R3 order", int'(out_d[i]), int'(w[i]));
        if (i > 0) check("R3 spacing", out_c[i] - out_c[i-1], exp_gap(1'b1));
      end
    end
    check("R3 no underrun", int'(underrun), 0);

    // Scenario C: full flag and dropped writes
    do_reset();
    half_rate = 1'b0;
    prime_level = CW'(127);
    for (int i = 0; i < DEPTH; i++) begin
      wr(DW'(32'h1000 + i), i == 0);
      if (i == DEPTH - 2) check("R10 not full at depth-1", int'(wr_full), 0);
    end
    check("R10 full at depth", int'(wr_full), 1);
    check("R5 above depth never starts", int'(pix_en), 0);
    wr_en = 1'b1;
    wr_data = DW'(32'hBADBAD);
    wr_sol = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 still full", int'(wr_full), 1);
      check("R10 dropped tag no start", int'(pix_en), 0);
    end
    wr_en = 1'b0;
    wr_sol = 1'b0;
    prime_level = CW'(1);
    repeat (80) @(negedge clk);
    check("R10 drained count", int'(out_d.size() > DEPTH), 1);
    if (out_d.size() > DEPTH) begin
      for (int i = 0; i < DEPTH; i++)
        check("R10 stored words", int'(out_d[i]), 32'h1000 + i);
      check("R10 dropped word absent", int'(out_d[DEPTH]), 32'h1000 + DEPTH - 1);
    end
    check("R9 underrun after drain", int'(underrun), 1);
    check("R10 full released", int'(wr_full), 0);

    // Scenario D: random lines with gaps, both rates
    for (int run = 0; run < 2; run++) begin
      do_reset();
      half_rate = run[0];
      prime_level = CW'(127);
      exp_d.delete();
      exp_first.delete();
      for (int ln = 0; ln < 6; ln++) begin
        int len;
        len = 1 + int'($urandom % 16);
        for (int j = 0; j < len; j++) begin
          logic [DW-1:0] d;
          d = rnd_pix();
          exp_d.push_back(d);
          exp_first.push_back(j == 0);
          wr(d, j == 0);
          if ($urandom % 4 == 0) repeat (int'($urandom % 3)) @(negedge clk);
        end
      end
      wr(rnd_pix(), 1'b1);
      repeat (400) @(negedge clk);
      check("R8 random pixel count", out_d.size(), exp_d.size());
      if (out_d.size() == exp_d.size())
        for (int k = 0; k < exp_d.size(); k++) begin
          check(run ? "R3 random data" : "R2 random data",
                int'(out_d[k]), int'(exp_d[k]));
          if (k > 0 && !exp_first[k])
            check(run ? "R3 random spacing" : "R2 random spacing",
                  out_c[k] - out_c[k-1], exp_gap(run[0]));
        end
      check("R9 random no underrun", int'(underrun), 0);
    end

    summary();
    $finish;
  end
endmodule